// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block takes two 64-bit operands in double-precision layout and evaluates one of four relational predicates on them: unordered, equal, less-than or less-or-equal. Each accepted request yields a 64-bit boolean word and a flag that reports a signaling NaN among the operands. The order is decided from the sign bit and the raw biased exponent and fraction fields, with fixed rules for NaN operands and for zeros of either sign.

A request is presented with `in_valid` high for one cycle. The result, the flag and `out_valid` are registered and appear on the next clock edge. A new request may be issued every cycle. When no request is presented, the result word and the flag keep their last values.

Top module: `fpcmp_unit`

## Requirements
- R1: The result word is `64'h4000_0000_0000_0000` (only bit 62 set) for true and all zeros for false. No other value ever appears on `result`.
- R2: `pred_sel` selects the predicate: 0 unordered, 1 equal, 2 less-than (A < B), 3 less-or-equal (A <= B). The result and flag for a request with `in_valid` high appear one clock edge later, together with `out_valid` high.
- R3: The unordered predicate is true exactly when at least one operand is a NaN (exponent field all ones, fraction field nonzero).
- R4: Equal, less-than and less-or-equal are false whenever at least one operand is a NaN.
- R5: `invalid` is set for every predicate when at least one operand is a signaling NaN (a NaN with fraction bit 51 clear). Quiet NaNs (fraction bit 51 set) and non-NaN operands leave it clear.
- R6: Zeros of either sign are equal to each other. Less-than on two zeros is false, and less-or-equal on two zeros is true.
- R7: With A negative and B positive (not both zero), A is less. With A positive and B negative, A is not less.
- R8: With equal signs, the order follows the magnitude formed by the exponent and fraction fields. For positive operands the smaller magnitude is the lesser. For negative operands the larger magnitude is the lesser. Infinities and subnormals are included.
- R9: Apart from two zeros, equal holds only when the two 64-bit words are bit-identical.
- R10: A cycle with `in_valid` low drives `out_valid` low on the next edge and leaves `result` and `invalid` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | Left operand A |
| op_b | input | 64 | Right operand B |
| pred_sel | input | 2 | Predicate select (0 unord, 1 eq, 2 lt, 3 le) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Boolean result word |
| invalid | output | 1 | Signaling NaN seen in the request |

## Verification
Every output of this block is due exactly one rising edge after the request that produced it. The bench drives each request on a falling edge and waits through the following rising edge. It then samples `out_valid`, `result` and `invalid` on the next falling edge, half a period after they settle. The sweep sends every ordered pair from a set of sixteen representative operands under all four predicates. The expected boolean comes from real-valued comparison of the operands plus a field-level NaN test. A final idle cycle with changed operands confirms that nothing moves one edge after a cycle with no request.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int unsigned FP_EXP_W  = 11;
  localparam int unsigned FP_FRAC_W = 52;
  localparam int unsigned FP_TRUE_BIT = 62;

  typedef enum logic [1:0] {
    PRED_UNORD = 2'd0,
    PRED_EQ    = 2'd1,
    PRED_LT    = 2'd2,
    PRED_LE    = 2'd3
  } pred_e;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned MAG_W = EXP_W + FRAC_W,
  localparam int unsigned W     = 1 + MAG_W
) (
  input  logic [W-1:0]     word,
  output logic             sign,
  output logic             nan,
  output logic             snan,
  output logic             zero,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f  = word[W-2 -: EXP_W];
    frac_f = word[FRAC_W-1:0];
    sign   = word[W-1];
    mag    = word[MAG_W-1:0];
    nan    = (&exp_f) && (|frac_f);
    // quiet bit is the top fraction bit
    snan   = nan && !frac_f[FRAC_W-1];
    zero   = ~|mag;
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int unsigned MAG_W = 63
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic             zero_a,
  input  logic             zero_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             eq,
  output logic             lt,
  output logic             le
);
  logic both_zero, mag_gt, mag_lt, mag_eq;

  always_comb begin
    both_zero = zero_a && zero_b;
    mag_gt    = mag_a > mag_b;
    mag_lt    = mag_a < mag_b;
    mag_eq    = mag_a == mag_b;
    eq        = both_zero || ((sign_a == sign_b) && mag_eq);
    if (both_zero) begin
      lt = 1'b0;
      le = 1'b1;
    end else if (sign_a != sign_b) begin
      lt = sign_a;
      le = sign_a;
    end else if (sign_a) begin
      lt = mag_gt;
      le = mag_gt || mag_eq;
    end else begin
      lt = mag_lt;
      le = mag_lt || mag_eq;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int unsigned EXP_W    = FP_EXP_W,
  parameter int unsigned FRAC_W   = FP_FRAC_W,
  parameter int unsigned TRUE_BIT = FP_TRUE_BIT,
  localparam int unsigned MAG_W   = EXP_W + FRAC_W,
  localparam int unsigned W       = 1 + MAG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   pred_sel,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         invalid
);
  localparam logic [W-1:0] TRUE_WORD = {{(W-1){1'b0}}, 1'b1} << TRUE_BIT;

  logic             sgn [2];
  logic             isnan [2];
  logic             issnan [2];
  logic             iszero [2];
  logic [MAG_W-1:0] mag [2];
  logic [W-1:0]     words [2];

  assign words[0] = op_a;
  assign words[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (words[i]),
      .sign (sgn[i]),
      .nan  (isnan[i]),
      .snan (issnan[i]),
      .zero (iszero[i]),
      .mag  (mag[i])
    );
  end

  logic rel_eq, rel_lt, rel_le;

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .sign_a (sgn[0]),
    .sign_b (sgn[1]),
    .zero_a (iszero[0]),
    .zero_b (iszero[1]),
    .mag_a  (mag[0]),
    .mag_b  (mag[1]),
    .eq     (rel_eq),
    .lt     (rel_lt),
    .le     (rel_le)
  );

  logic any_nan, any_snan, hit;

  always_comb begin
    any_nan  = isnan[0] || isnan[1];
    any_snan = issnan[0] || issnan[1];
    unique case (pred_e'(pred_sel))
      PRED_UNORD: hit = any_nan;
      PRED_EQ:    hit = !any_nan && rel_eq;
      PRED_LT:    hit = !any_nan && rel_lt;
      default:    hit = !any_nan && rel_le;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= hit ? TRUE_WORD : '0;
        invalid <= any_snan;
      end
    end
  end

  assert_encoding_R1: assert property (@(posedge clk) disable iff (rst)
    (result == '0) || (result == TRUE_WORD));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_unord_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && (pred_sel == 2'd0) && any_nan |=> result == TRUE_WORD);

  assert_nan_false_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (pred_sel != 2'd0) && any_nan |=> result == '0);

  assert_snan_flag_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && (issnan[0] || issnan[1]) |=> invalid);

  assert_quiet_noflag_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && !issnan[0] && !issnan[1] |=> !invalid);

  assert_zero_eq_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && iszero[0] && iszero[1] && (pred_sel == 2'd1) |=> result == TRUE_WORD);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result) && $stable(invalid));
endmodule

// File: tb/fpcmp_unit_bench.sv
`timescale 1ns/1ps
module fpcmp_unit_bench;
  localparam logic [63:0] TRUE_W = 64'h4000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  pred_sel = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fpcmp_unit u_fpcmp_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .pred_sel(pred_sel), .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  logic [63:0] vals [16];
  initial begin
    vals[0]  = 64'h0000_0000_0000_0000; // +0
    vals[1]  = 64'h8000_0000_0000_0000; // -0
    vals[2]  = 64'h3FF0_0000_0000_0000; // 1.0
    vals[3]  = 64'hBFF0_0000_0000_0000; // -1.0
    vals[4]  = 64'h3FF8_0000_0000_0000; // 1.5
    vals[5]  = 64'hBFF8_0000_0000_0000; // -1.5
    vals[6]  = 64'h4000_0000_0000_0000; // 2.0
    vals[7]  = 64'h0000_0000_0000_0001; // min subnormal
    vals[8]  = 64'h8000_0000_0000_0001; // -min subnormal
    vals[9]  = 64'h7FF0_0000_0000_0000; // +inf
    vals[10] = 64'hFFF0_0000_0000_0000; // -inf
    vals[11] = 64'h7FF8_0000_0000_0000; // quiet NaN
    vals[12] = 64'h7FF0_0000_0000_0001; // signaling NaN
    vals[13] = 64'hFFF8_0000_0000_0005; // negative quiet NaN
    vals[14] = 64'h7FEF_FFFF_FFFF_FFFF; // max finite
    vals[15] = 64'h3FF0_0000_0000_0001; // 1.0 + ulp
  end

  function automatic logic f_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic logic f_snan(logic [63:0] v);
    return f_nan(v) && !v[51];
  endfunction

  function automatic logic f_zero(logic [63:0] v);
    return v[62:0] == 63'd0;
  endfunction

  function automatic logic f_expect(logic [63:0] a, logic [63:0] b, logic [1:0] p);
    real ra, rb;
    logic nan_any;
    nan_any = f_nan(a) || f_nan(b);
    if (p == 2'd0) return nan_any;
    if (nan_any) return 1'b0;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    case (p)
      2'd1:    return ra == rb;
      2'd2:    return ra < rb;
      default: return ra <= rb;
    endcase
  endfunction

  function automatic string f_tag(logic [63:0] a, logic [63:0] b, logic [1:0] p);
    if (f_nan(a) || f_nan(b)) return (p == 2'd0) ? "R3" : "R4";
    if (p == 2'd0) return "R3";
    if (f_zero(a) && f_zero(b)) return "R6";
    if (p == 2'd1) return "R9";
    if (a[63] != b[63]) return "R7";
    return "R8";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic issue(logic [63:0] a, logic [63:0] b, logic [1:0] p);
    @(negedge clk);
    op_a = a; op_b = b; pred_sel = p; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R2 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    check("R5 reset flag", {63'd0, invalid}, 64'd0);

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        for (int p = 0; p < 4; p++) begin
          issue(vals[i], vals[j], 2'(p));
          // outputs are sampled at the negedge following the capture edge
          check("R2 valid", {63'd0, out_valid}, 64'd1);
          check(f_tag(vals[i], vals[j], 2'(p)), result,
                f_expect(vals[i], vals[j], 2'(p)) ? TRUE_W : 64'd0);
          check("R5 flag", {63'd0, invalid},
                {63'd0, f_snan(vals[i]) || f_snan(vals[j])});
          check("R1 encoding", {63'd0, (result == 64'd0) || (result == TRUE_W)}, 64'd1);
        end
      end
    end

    // R10: set up a known true result, then idle with operands that would change it
    issue(vals[12], vals[2], 2'd0);
    check("R3 setup", result, TRUE_W);
    check("R5 setup", {63'd0, invalid}, 64'd1);
    op_a = vals[2]; op_b = vals[3]; pred_sel = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check("R10 valid low", {63'd0, out_valid}, 64'd0);
    check("R10 result held", result, TRUE_W);
    check("R10 flag held", {63'd0, invalid}, 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule